// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the byte-wide bus front end of a three-channel interval timer. It sits at four byte addresses: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the control port. Control words written to the control port program each channel's access pattern, operating mode and decimal-counting flag. The same port also accepts snapshot commands, which freeze a channel's count, its status, or both, until software reads them.

The counting engines are outside this block. They present their live 16-bit counts and output pins to it. In return, the block sends them a one-cycle load strobe together with the 16-bit value assembled from data-port writes. Reads are combinational: `rdata_o` is valid in the cycle in which `rd_en_i` is high, and the read's side effects take hold at the next clock edge. A write and a read are never issued in the same cycle; if they are, the write wins.

Control word fields: bits 7:6 select the channel, and the value 3 in that field marks a multi-channel snapshot command. Bits 5:4 set the access pattern: 0 snapshots the count, 1 transfers the low byte only, 2 the high byte only, 3 the low byte then the high byte. Bits 3:1 set the operating mode and bit 0 sets the decimal flag.

Top module: `tmr_ctl_if`

## Requirements
- R1: After reset, every channel has access pattern 3 (low then high), operating mode 0 and decimal flag 0. No snapshot is pending, both byte toggles point to the first byte, and `load_stb_o` is zero.
- R2: A control word with channel field 0..2 and access field 1..3 stores that channel's access, mode and decimal flag. It shows the mode on `mode_o[3*ch+2:3*ch]` and the flag on `bcd_o[ch]`.
- R3: A control word with access field 0 snapshots the selected channel's live count and leaves its access, mode and flag unchanged. Reads of the snapshot follow the access pattern: low byte, high byte, or low then high. After the snapshot has been read, reads return the live count.
- R4: While a count snapshot is unread, a new count snapshot request has no effect. While a status snapshot is unread, a new status snapshot request has no effect.
- R5: A control word with channel field 3 is a snapshot command. Its bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low requests a count snapshot and bit 4 low requests a status snapshot, for each selected channel. Unselected channels are untouched.
- R6: The status byte is {output pin, 0, access[1:0], mode[2:0], flag}, with the output pin in bit 7. Its fields are captured at the edge that accepts the command.
- R7: On a data-port read, a pending status byte is returned first, then a pending count snapshot, then the live count.
- R8: With no snapshot pending, a live read returns the low byte for access 1 and the high byte for access 2. For access 3 it returns the low and high bytes alternately, starting with the low byte.
- R9: A data write with access 1 loads {8'h00, byte} and one with access 2 loads {byte, 8'h00}. With access 3, the first byte is held and the second loads {second, first}. A load appears one cycle after the write edge as a one-hot `load_stb_o` with the value on `load_val_o`.
- R10: Each channel has its own read toggle and write toggle. Traffic on one channel leaves the others' toggles unchanged, and a mode-setting control word returns both toggles of its channel to the first byte.
- R11: A read of the control port returns 8'h00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 2 | Address: 0..2 data ports, 3 control port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, valid while rd_en_i is high |
| live_cnt_i | input | 48 | Live counts, channel n in bits 16n+15:16n |
| out_i | input | 3 | Channel output pins |
| load_stb_o | output | 3 | One-cycle count load strobe per channel |
| load_val_o | output | 16 | Count value for the active load strobe |
| mode_o | output | 9 | Operating mode, channel n in bits 3n+2:3n |
| bcd_o | output | 3 | Decimal counting flag per channel |

## Verification
A byte toggle in the wrong state shows up on the very next access to that channel: the wrong byte half comes back on a read, or a load strobe fires early or not at all on a write. A snapshot flag that fails to clear, or clears too early, swaps frozen and live data. The bench detects this by changing the live counts between the snapshot and the read, so the error is visible within one or two reads. A mis-decoded control word is caught through the status byte, because that byte reflects every stored field.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SNAP_NONE = 2'd0,
    SNAP_LO   = 2'd1,
    SNAP_HI   = 2'd2,
    SNAP_WORD = 2'd3
  } snap_e;

  typedef struct packed {
    logic       set_mode;
    logic       snap_cnt;
    logic       snap_stat;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_ctl_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  cw_wr_i,
  input  logic [7:0]            cw_i,
  output chan_cmd_t [NCH-1:0]   cmd_o
);
  localparam logic [1:0] MULTI_SEL = 2'd3;

  logic [1:0] sel;
  acc_e       acc;
  assign sel = cw_i[7:6];
  assign acc = acc_e'(cw_i[5:4]);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cmd_o[i]      = '0;
      cmd_o[i].acc  = acc;
      cmd_o[i].mode = cw_i[3:1];
      cmd_o[i].bcd  = cw_i[0];
      if (cw_wr_i) begin
        if (sel == MULTI_SEL) begin
          if (cw_i[1+i]) begin
            // active-low selectors
            cmd_o[i].snap_cnt  = !cw_i[5];
            cmd_o[i].snap_stat = !cw_i[4];
          end
        end else if (sel == 2'(i)) begin
          if (acc == ACC_SNAP) cmd_o[i].snap_cnt = 1'b1;
          else                 cmd_o[i].set_mode = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chan_cmd_t        cmd_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] live_i,
  input  logic             out_i,
  output logic [7:0]       rdata_o,
  output logic             ld_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic [2:0]       mode_o,
  output logic             bcd_o
);
  acc_e             acc_q;
  logic [2:0]       mode_q;
  logic             bcd_q;
  logic             rd_tog_q, wr_tog_q;
  logic [7:0]       wr_hold_q;
  snap_e            snap_q;
  logic [CNT_W-1:0] snap_cnt_q;
  logic             stat_pend_q;
  logic [7:0]       stat_q;
  logic             ld_q;
  logic [CNT_W-1:0] ld_val_q;

  always_comb begin
    rdata_o = 8'h00;
    if (stat_pend_q) begin
      rdata_o = stat_q;
    end else if (snap_q != SNAP_NONE) begin
      rdata_o = (snap_q == SNAP_HI) ? snap_cnt_q[15:8] : snap_cnt_q[7:0];
    end else begin
      unique case (acc_q)
        ACC_LO:   rdata_o = live_i[7:0];
        ACC_HI:   rdata_o = live_i[15:8];
        ACC_WORD: rdata_o = rd_tog_q ? live_i[15:8] : live_i[7:0];
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= ACC_WORD;
      mode_q      <= '0;
      bcd_q       <= 1'b0;
      rd_tog_q    <= 1'b0;
      wr_tog_q    <= 1'b0;
      wr_hold_q   <= '0;
      snap_q      <= SNAP_NONE;
      snap_cnt_q  <= '0;
      stat_pend_q <= 1'b0;
      stat_q      <= '0;
      ld_q        <= 1'b0;
      ld_val_q    <= '0;
    end else begin
      ld_q <= 1'b0;
      if (rd_i) begin
        if (stat_pend_q)                stat_pend_q <= 1'b0;
        else if (snap_q == SNAP_WORD)   snap_q <= SNAP_HI;
        else if (snap_q != SNAP_NONE)   snap_q <= SNAP_NONE;
        else if (acc_q == ACC_WORD)     rd_tog_q <= !rd_tog_q;
      end
      if (cmd_i.set_mode) begin
        acc_q    <= cmd_i.acc;
        mode_q   <= cmd_i.mode;
        bcd_q    <= cmd_i.bcd;
        rd_tog_q <= 1'b0;
        wr_tog_q <= 1'b0;
      end
      if (cmd_i.snap_cnt && snap_q == SNAP_NONE) begin
        snap_cnt_q <= live_i;
        snap_q     <= snap_e'(2'(acc_q));
      end
      if (cmd_i.snap_stat && !stat_pend_q) begin
        stat_q      <= {out_i, 1'b0, 2'(acc_q), mode_q, bcd_q};
        stat_pend_q <= 1'b1;
      end
      if (wr_i) begin
        unique case (acc_q)
          ACC_LO: begin
            ld_q     <= 1'b1;
            ld_val_q <= {8'h00, wdata_i};
          end
          ACC_HI: begin
            ld_q     <= 1'b1;
            ld_val_q <= {wdata_i, 8'h00};
          end
          ACC_WORD: begin
            if (!wr_tog_q) begin
              wr_hold_q <= wdata_i;
              wr_tog_q  <= 1'b1;
            end else begin
              ld_q     <= 1'b1;
              ld_val_q <= {wdata_i, wr_hold_q};
              wr_tog_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ld_o     = ld_q;
  assign ld_val_o = ld_val_q;
  assign mode_o   = mode_q;
  assign bcd_o    = bcd_q;

  // R4
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_q != SNAP_NONE && cmd_i.snap_cnt && !rd_i) |=> $stable(snap_cnt_q));

  // R10
  tog_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.set_mode |=> (!rd_tog_q && !wr_tog_q));

  // R6
  stat_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.snap_stat && !stat_pend_q) |=>
      (stat_pend_q && stat_q[6] == 1'b0 && stat_q[7] == $past(out_i) && stat_q[0] == $past(bcd_q)));

  // R7
  stat_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && stat_pend_q && !cmd_i.snap_cnt) |=> (!stat_pend_q && snap_q == $past(snap_q)));
endmodule

// File: rtl/tmr_ctl_if.sv
module tmr_ctl_if
  import tmr_ctl_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [1:0]             addr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [NCH*CNT_W-1:0]   live_cnt_i,
  input  logic [NCH-1:0]         out_i,
  output logic [NCH-1:0]         load_stb_o,
  output logic [CNT_W-1:0]       load_val_o,
  output logic [NCH*3-1:0]       mode_o,
  output logic [NCH-1:0]         bcd_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  chan_cmd_t [NCH-1:0]   cmd;
  logic [NCH-1:0][7:0]   ch_rdata;
  logic [NCH-1:0][CNT_W-1:0] ch_ld_val;
  logic                  cw_wr;

  assign cw_wr = wr_en_i && (addr_i == CTRL_ADDR);

  tmr_cw_decode #(.NCH(NCH)) u_dec (
    .cw_wr_i (cw_wr),
    .cw_i    (wdata_i),
    .cmd_o   (cmd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_wr, ch_rd;
    assign ch_wr = wr_en_i && (addr_i == 2'(g));
    assign ch_rd = rd_en_i && !wr_en_i && (addr_i == 2'(g));

    tmr_chan_regs u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd[g]),
      .wr_i     (ch_wr),
      .rd_i     (ch_rd),
      .wdata_i  (wdata_i),
      .live_i   (live_cnt_i[g*CNT_W +: CNT_W]),
      .out_i    (out_i[g]),
      .rdata_o  (ch_rdata[g]),
      .ld_o     (load_stb_o[g]),
      .ld_val_o (ch_ld_val[g]),
      .mode_o   (mode_o[g*3 +: 3]),
      .bcd_o    (bcd_o[g])
    );

    // R9
    ld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_stb_o[g] |-> $past(wr_en_i && addr_i == 2'(g)));
  end

  always_comb begin
    rdata_o    = 8'h00;
    load_val_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == 2'(i)) rdata_o = ch_rdata[i];
      if (load_stb_o[i])   load_val_o = load_val_o | ch_ld_val[i];
    end
  end

  // R9
  ld_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_stb_o));
endmodule

// File: tb/tmr_ctl_if_tb.sv
module tmr_ctl_if_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] live [NCH];
  logic [NCH*16-1:0] live_cnt;
  logic [NCH-1:0] outp = '0;
  logic [NCH-1:0] ld_stb;
  logic [15:0] ld_val;
  logic [NCH*3-1:0] mode;
  logic [NCH-1:0] bcd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = !clk;
  assign live_cnt = {live[2], live[1], live[0]};

  tmr_ctl_if #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .live_cnt_i(live_cnt), .out_i(outp), .load_stb_o(ld_stb),
    .load_val_o(ld_val), .mode_o(mode), .bcd_o(bcd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] cw(int ch, int acc, int md, int b);
    return 8'((ch << 6) | (acc << 4) | (md << 1) | b);
  endfunction

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < NCH; i++) live[i] = 16'h1234 + 16'(i * 16'h1111);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 mode", int'(mode), 0);
    chk("R1 bcd", int'(bcd), 0);
    chk("R1 stb", int'(ld_stb), 0);
    rd(2'd0, d); chk("R1 live lo", d, 8'h34);
    rd(2'd0, d); chk("R1 live hi", d, 8'h12);
    wr(2'd3, 8'hE0 | 8'h02);
    rd(2'd0, d); chk("R1 status", d, 8'h30);

    // R2 R6 R7 R8: sweep every channel, access, mode, flag
    for (int ch = 0; ch < NCH; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int md = 0; md < 8; md++)
          for (int b = 0; b < 2; b++) begin
            int o;
            o = (md ^ acc ^ ch) & 1;
            live[ch] = 16'((md * 16'h0913) ^ (acc << 12) ^ b);
            wr(2'd3, cw(ch, acc, md, b));
            chk("R2 mode", int'(mode[ch*3 +: 3]), md);
            chk("R2 bcd", int'(bcd[ch]), b);
            outp[ch] = o[0];
            wr(2'd3, 8'hE0 | 8'(2 << ch));
            outp[ch] = !o[0];
            rd(2'(ch), d);
            chk("R6 status", d, (o << 7) | (acc << 4) | (md << 1) | b);
            rd(2'(ch), d);
            chk("R7 R8 live after status", d,
                acc == 2 ? int'(live[ch][15:8]) : int'(live[ch][7:0]));
          end

    // R9: write assembly for every channel and access pattern
    for (int ch = 0; ch < NCH; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] b0, b1;
          b0 = 8'(k * 8'h5A + 8'h81);
          b1 = 8'(~b0 ^ 8'(ch));
          wr(2'd3, cw(ch, acc, 0, 0));
          wr(2'(ch), b0);
          if (acc == 1) begin
            chk("R9 lo stb", int'(ld_stb), 1 << ch);
            chk("R9 lo val", int'(ld_val), int'(b0));
          end else if (acc == 2) begin
            chk("R9 hi stb", int'(ld_stb), 1 << ch);
            chk("R9 hi val", int'(ld_val), int'(b0) << 8);
          end else begin
            chk("R9 word first no stb", int'(ld_stb), 0);
            wr(2'(ch), b1);
            chk("R9 word stb", int'(ld_stb), 1 << ch);
            chk("R9 word val", int'(ld_val), (int'(b1) << 8) | int'(b0));
          end
          @(negedge clk);
          chk("R9 stb one cycle", int'(ld_stb), 0);
        end

    // R10: independent toggles and reset on mode set
    wr(2'd3, cw(0, 3, 2, 0));
    wr(2'd3, cw(1, 3, 2, 0));
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h22);
    chk("R10 ch1 first", int'(ld_stb), 0);
    wr(2'd1, 8'h33);
    chk("R10 ch1 val", int'(ld_val), 16'h3322);
    wr(2'd0, 8'h44);
    chk("R10 ch0 val", int'(ld_val), 16'h4411);
    wr(2'd3, cw(2, 3, 0, 0));
    wr(2'd2, 8'h99);
    wr(2'd3, cw(2, 3, 0, 0));
    wr(2'd2, 8'h55);
    chk("R10 wr tog reset", int'(ld_stb), 0);
    wr(2'd2, 8'h66);
    chk("R10 wr tog reset val", int'(ld_val), 16'h6655);
    live[0] = 16'hBEEF; live[1] = 16'hCAFE;
    rd(2'd0, d);
    rd(2'd1, d); chk("R10 ch1 rd lo", d, 8'hFE);
    rd(2'd0, d); chk("R10 ch0 rd hi", d, 8'hBE);
    rd(2'd0, d);
    wr(2'd3, cw(0, 3, 2, 0));
    rd(2'd0, d); chk("R10 rd tog reset", d, 8'hEF);
    rd(2'd1, d); chk("R10 ch1 rd hi", d, 8'hCA);

    // R3 R4: count snapshot, word access
    wr(2'd3, cw(1, 3, 5, 1));
    live[1] = 16'hABCD;
    wr(2'd3, cw(1, 0, 0, 0));
    chk("R3 mode kept", int'(mode[5:3]), 5);
    chk("R3 bcd kept", int'(bcd[1]), 1);
    live[1] = 16'h0201;
    wr(2'd3, cw(1, 0, 0, 0));
    rd(2'd1, d); chk("R3 R4 snap lo", d, 8'hCD);
    rd(2'd1, d); chk("R3 R4 snap hi", d, 8'hAB);
    rd(2'd1, d); chk("R3 live after snap", d, 8'h01);
    rd(2'd1, d); chk("R3 live after snap hi", d, 8'h02);

    // R3: low-only and high-only snapshots
    wr(2'd3, cw(2, 1, 0, 0));
    live[2] = 16'h7788;
    wr(2'd3, cw(2, 0, 0, 0));
    live[2] = 16'h1122;
    rd(2'd2, d); chk("R3 lo snap", d, 8'h88);
    rd(2'd2, d); chk("R3 lo live", d, 8'h22);
    wr(2'd3, cw(2, 2, 0, 0));
    live[2] = 16'h7788;
    wr(2'd3, cw(2, 0, 0, 0));
    live[2] = 16'h1122;
    rd(2'd2, d); chk("R3 hi snap", d, 8'h77);
    rd(2'd2, d); chk("R3 hi live", d, 8'h11);

    // R5 R7: multi-channel command, count and status, ch0 and ch2
    wr(2'd3, cw(0, 3, 3, 0));
    wr(2'd3, cw(1, 3, 4, 0));
    wr(2'd3, cw(2, 3, 1, 1));
    live[0] = 16'h5A01; live[1] = 16'h5A02; live[2] = 16'h5A03;
    outp = 3'b101;
    wr(2'd3, 8'hC0 | 8'h02 | 8'h08);
    live[0] = 16'h0F0F; live[1] = 16'h0E0E; live[2] = 16'h0D0D;
    outp = 3'b000;
    rd(2'd1, d); chk("R5 ch1 untouched", d, 8'h0E);
    rd(2'd0, d); chk("R5 R7 ch0 status", d, 8'hB6);
    rd(2'd0, d); chk("R7 ch0 snap lo", d, 8'h01);
    rd(2'd0, d); chk("R7 ch0 snap hi", d, 8'h5A);
    rd(2'd0, d); chk("R7 ch0 live", d, 8'h0F);
    rd(2'd2, d); chk("R5 ch2 status", d, 8'hB3);
    rd(2'd2, d); chk("R5 ch2 snap lo", d, 8'h03);
    // count only via multi command on ch1
    wr(2'd3, 8'hC0 | 8'h10 | 8'h04);
    live[1] = 16'h3333;
    rd(2'd1, d); chk("R5 ch1 count only", d, 8'h0E);

    // R4: status snapshot held while unread
    outp[2] = 1'b1;
    wr(2'd3, 8'hE0 | 8'h08);
    outp[2] = 1'b0;
    wr(2'd3, 8'hE0 | 8'h08);
    rd(2'd2, d); chk("R4 status held", d, 8'hB3);

    // R11: control port read
    live[0] = 16'h4321;
    wr(2'd3, cw(0, 3, 0, 0));
    rd(2'd3, d); chk("R11 ctrl read", d, 8'h00);
    rd(2'd0, d); chk("R11 no side effect", d, 8'h21);

    finish_sim();
  end
endmodule